// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a 16-bit successive-approximation converter. A falling edge on the active-low convert-start input begins a conversion, provided the block is ready to accept one. The block then runs a binary search, most significant bit first. It places each trial code on `dac_code` for the capacitor array, reads the comparator answer on `cmp_in`, and keeps or clears the bit on trial. `busy` stays high for the whole search. The finished code appears on `result` on the same clock edge that `busy` falls, so there is no pipeline latency.

A speed select sets how many system clocks each bit trial lasts. The fastest mode also limits how long the converter may sit idle between conversions. A range select and an output-coding select decide whether the code is straight binary or two's complement. The speed, range and coding settings are captured when a conversion starts, so a new setting applies from the next conversion and no reset is needed.

The controller has three states. ST_ACQ is the acquisition wait that follows reset and every conversion; it moves to ST_READY after `ACQ_CLKS` clocks. ST_READY accepts a start edge and moves to ST_TRIAL. ST_TRIAL runs the search and returns to ST_ACQ when the last bit is decided.

Top module: `sar_seq`

## Requirements
- R1: A conversion starts only in ST_READY, on a clock edge that samples `conv_start_n` low after the previous edge sampled it high. `busy` is high from that edge onward.
- R2: The first trial code is 0x8000. On each trial, `cmp_in`=1 keeps the bit under trial and `cmp_in`=0 clears it, and the next lower bit is then set. With a comparator that answers (input code >= `dac_code`), the result equals the input code.
- R3: `busy` stays high for exactly 16*T clock edges. T is 4 for `mode_sel`=01 (fast), 5 for 00 or 11 (normal) and 6 for 10 (impulse).
- R4: `result` and `result_bad` update on the edge where `busy` falls and hold their values while `busy` is high.
- R5: A start edge is ignored while `busy` is high and during the `ACQ_CLKS` acquisition clocks. Holding `conv_start_n` low does not start another conversion.
- R6: `mode_sel`, `range_sel` and `twos_sel` are captured on the start edge. A change during a conversion applies only from the next conversion. `range_act` shows the captured range.
- R7: `range_sel` 00 and 01 are unipolar ranges, and their output is always straight binary. `range_sel` 10 and 11 are bipolar ranges centred at midscale; for these, `twos_sel`=1 inverts the MSB to give two's complement.
- R8: After a fast-mode conversion, if more than `IDLE_MAX` clock edges pass after `busy` falls with no new start, `idle_overrun` rises. It stays high until reset.
- R9: The first result completed after an overrun has `result_bad`=1. Later results have `result_bad`=0.
- R10: After a normal-mode or impulse-mode conversion, no idle limit applies.
- R11: During and after reset, `busy`, `result`, `result_bad`, `idle_overrun`, `range_act` and `dac_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start_n | input | 1 | Convert start; its falling edge starts a conversion |
| cmp_in | input | 1 | Comparator answer; 1 means the input is at or above the trial level |
| mode_sel | input | 2 | Speed mode: 01 fast, 10 impulse, 00/11 normal |
| range_sel | input | 2 | Input range; bit 1 set means bipolar |
| twos_sel | input | 1 | Two's-complement output for bipolar ranges |
| busy | output | 1 | High while the search runs |
| dac_code | output | W | Trial code driven to the capacitor array; zero when idle |
| result | output | W | Last finished conversion code |
| range_act | output | 2 | Range captured for the current or last conversion |
| result_bad | output | 1 | The current result followed an idle overrun |
| idle_overrun | output | 1 | Sticky flag: the fast-mode idle limit was exceeded |

## Verification
`busy` rises on the first edge that samples the start edge, and `dac_code` shows 0x8000 at the falling clock edge after that. The bench counts the falling clock edges on which `busy` is seen high and compares the count with 16*T. It reads `result`, `result_bad` and `range_act` at the first falling clock edge where `busy` is low, one half-cycle after they are registered. The overrun appears `IDLE_MAX`+1 edges after `busy` falls, so the bench checks it only after idle gaps well below or well above that point, with tens of cycles of margin on each side.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_ACQ   = 2'd0,
        ST_READY = 2'd1,
        ST_TRIAL = 2'd2
    } seq_state_t;

    localparam logic [1:0] SPD_NORMAL  = 2'b00;
    localparam logic [1:0] SPD_FAST    = 2'b01;
    localparam logic [1:0] SPD_IMPULSE = 2'b10;

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] range;
        logic       twos;
    } conv_cfg_t;

endpackage

// File: rtl/sar_seq_timing.sv
module sar_seq_timing #(
    parameter int FAST_CLKS = 4,
    parameter int NORM_CLKS = 5,
    parameter int IMP_CLKS  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       run,
    input  logic [1:0] mode,
    output logic       trial_end
);
    import sar_seq_pkg::*;

    localparam int MAX_AB = (FAST_CLKS > NORM_CLKS) ? FAST_CLKS : NORM_CLKS;
    localparam int MAX_C  = (MAX_AB > IMP_CLKS) ? MAX_AB : IMP_CLKS;
    localparam int TCW    = $clog2(MAX_C + 1);

    logic [TCW-1:0] len_m1;
    logic [TCW-1:0] tick_q;

    // per-trial length chosen by the captured speed mode
    always_comb begin
        unique case (mode)
            SPD_FAST:    len_m1 = TCW'(FAST_CLKS - 1);
            SPD_IMPULSE: len_m1 = TCW'(IMP_CLKS - 1);
            default:     len_m1 = TCW'(NORM_CLKS - 1);
        endcase
    end

    assign trial_end = run && (tick_q == len_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (load) begin
            tick_q <= '0;
        end else if (run) begin
            tick_q <= trial_end ? '0 : tick_q + 1'b1;
        end
    end

endmodule

// File: rtl/sar_seq_search.sv
module sar_seq_search #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         cmp_in,
    output logic [W-1:0] trial_code,
    output logic [W-1:0] next_code,
    output logic         last_bit
);
    localparam int IDXW = $clog2(W);

    logic [W-1:0]    code_q;
    logic [IDXW-1:0] idx_q;

    // each bit: decided when under trial, set when it is the next trial
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [IDXW-1:0] SELF = IDXW'(i);
        localparam logic [IDXW-1:0] NXT  = IDXW'((i + 1) % W);
        localparam bit              HAS_NXT = (i < W - 1);
        assign next_code[i] = (idx_q == SELF) ? cmp_in :
                              ((HAS_NXT && (idx_q == NXT)) ? 1'b1 : code_q[i]);
    end

    assign trial_code = code_q;
    assign last_bit   = (idx_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            code_q <= {1'b1, {(W-1){1'b0}}};
            idx_q  <= IDXW'(W - 1);
        end else if (step) begin
            code_q <= next_code;
            if (idx_q != '0) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_seq_idle_mon.sv
module sar_seq_idle_mon #(
    parameter int IDLE_MAX = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start,
    input  logic conv_done,
    input  logic fast_mode,
    output logic overrun,
    output logic stale_pend
);
    localparam int CW = $clog2(IDLE_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            armed_q    <= 1'b0;
            overrun    <= 1'b0;
            stale_pend <= 1'b0;
        end else if (conv_start) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (conv_done) begin
            cnt_q      <= '0;
            armed_q    <= fast_mode;
            stale_pend <= 1'b0;
        end else if (armed_q) begin
            if (cnt_q == CW'(IDLE_MAX)) begin
                overrun    <= 1'b1;
                stale_pend <= 1'b1;
                armed_q    <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_seq_format.sv
module sar_seq_format #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw,
    input  logic [1:0]   range,
    input  logic         twos,
    output logic [W-1:0] coded
);
    logic flip;

    assign flip  = range[1] && twos;
    assign coded = flip ? {~raw[W-1], raw[W-2:0]} : raw;

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int W         = 16,
    parameter int FAST_CLKS = 4,
    parameter int NORM_CLKS = 5,
    parameter int IMP_CLKS  = 6,
    parameter int ACQ_CLKS  = 4,
    parameter int IDLE_MAX  = 50000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_start_n,
    input  logic         cmp_in,
    input  logic [1:0]   mode_sel,
    input  logic [1:0]   range_sel,
    input  logic         twos_sel,
    output logic         busy,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] result,
    output logic [1:0]   range_act,
    output logic         result_bad,
    output logic         idle_overrun
);
    import sar_seq_pkg::*;

    localparam int ACW = $clog2(ACQ_CLKS + 1);

    seq_state_t     state_q, state_d;
    conv_cfg_t      cfg_q;
    logic           start_q;
    logic           start_fall;
    logic           conv_start;
    logic           conv_done;
    logic           run;
    logic           trial_end;
    logic           last_bit;
    logic           acq_done;
    logic           stale_pend;
    logic [ACW-1:0] acq_cnt;
    logic [W-1:0]   trial_code;
    logic [W-1:0]   next_code;
    logic [W-1:0]   coded;

    assign start_fall = start_q && !conv_start_n;
    assign acq_done   = (acq_cnt == ACW'(ACQ_CLKS - 1));
    assign conv_start = (state_q == ST_READY) && start_fall;
    assign conv_done  = (state_q == ST_TRIAL) && trial_end && last_bit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACQ;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQ:   if (acq_done)   state_d = ST_READY;
            ST_READY: if (start_fall) state_d = ST_TRIAL;
            ST_TRIAL: if (conv_done)  state_d = ST_ACQ;
            default:                  state_d = ST_ACQ;
        endcase
    end

    // state outputs
    always_comb begin
        busy     = 1'b0;
        run      = 1'b0;
        dac_code = '0;
        unique case (state_q)
            ST_TRIAL: begin
                busy     = 1'b1;
                run      = 1'b1;
                dac_code = trial_code;
            end
            default: ;
        endcase
    end

    // edge detect, acquisition timer, captured settings, result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q    <= 1'b1;
            acq_cnt    <= '0;
            cfg_q      <= '0;
            result     <= '0;
            result_bad <= 1'b0;
        end else begin
            start_q <= conv_start_n;
            acq_cnt <= (state_q == ST_ACQ && !acq_done) ? acq_cnt + 1'b1 : '0;
            if (conv_start) begin
                cfg_q.mode  <= mode_sel;
                cfg_q.range <= range_sel;
                cfg_q.twos  <= twos_sel;
            end
            if (conv_done) begin
                result     <= coded;
                result_bad <= stale_pend;
            end
        end
    end

    assign range_act = cfg_q.range;

    sar_seq_timing #(
        .FAST_CLKS(FAST_CLKS),
        .NORM_CLKS(NORM_CLKS),
        .IMP_CLKS (IMP_CLKS)
    ) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (conv_start),
        .run      (run),
        .mode     (cfg_q.mode),
        .trial_end(trial_end)
    );

    sar_seq_search #(.W(W)) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (conv_start),
        .step      (trial_end),
        .cmp_in    (cmp_in),
        .trial_code(trial_code),
        .next_code (next_code),
        .last_bit  (last_bit)
    );

    sar_seq_format #(.W(W)) u_format (
        .raw  (next_code),
        .range(cfg_q.range),
        .twos (cfg_q.twos),
        .coded(coded)
    );

    sar_seq_idle_mon #(.IDLE_MAX(IDLE_MAX)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_start(conv_start),
        .conv_done (conv_done),
        .fast_mode (cfg_q.mode == SPD_FAST),
        .overrun   (idle_overrun),
        .stale_pend(stale_pend)
    );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int W         = 16,
    parameter int FAST_CLKS = 4,
    parameter int NORM_CLKS = 5,
    parameter int IMP_CLKS  = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         conv_start_n,
    input logic [1:0]   mode_sel,
    input logic         busy,
    input logic [W-1:0] dac_code,
    input logic [W-1:0] result,
    input logic         result_bad,
    input logic         idle_overrun
);
    logic       busy_q;
    logic [1:0] mode_q;
    int         run_len;
    int         exp_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            mode_q  <= 2'b00;
            run_len <= 0;
            exp_len <= 0;
        end else begin
            busy_q  <= busy;
            mode_q  <= mode_sel;
            run_len <= busy ? run_len + 1 : 0;
            if (busy && !busy_q) begin
                exp_len <= 16 * ((mode_q == 2'b01) ? FAST_CLKS :
                                 (mode_q == 2'b10) ? IMP_CLKS : NORM_CLKS) * W / 16;
            end
        end
    end

    // R1: busy rises only right after a sampled high-to-low start edge
    p_start_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!$past(conv_start_n) && $past(conv_start_n, 2)));

    // R2: the search opens with the MSB trial
    p_first_trial_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (dac_code == {1'b1, {(W-1){1'b0}}}));

    // R3: conversion length follows the captured speed mode
    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !busy) |-> (run_len == exp_len));

    // R4: result held while converting
    p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(result));

    // R9: the invalid mark only moves when a conversion completes
    p_bad_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_bad) |-> $fell(busy));

    // R8: the overrun flag is sticky and only rises while idle
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(idle_overrun));

    p_idle_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_overrun) |-> !busy);

endmodule

bind sar_seq sar_seq_chk #(
    .W        (W),
    .FAST_CLKS(FAST_CLKS),
    .NORM_CLKS(NORM_CLKS),
    .IMP_CLKS (IMP_CLKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_start_n(conv_start_n),
    .mode_sel    (mode_sel),
    .busy        (busy),
    .dac_code    (dac_code),
    .result      (result),
    .result_bad  (result_bad),
    .idle_overrun(idle_overrun)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;

    localparam int IDLE_LIM = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start_n = 1'b1;
    logic        cmp_in;
    logic [1:0]  mode_sel = 2'b00;
    logic [1:0]  range_sel = 2'b00;
    logic        twos_sel = 1'b0;
    logic        busy;
    logic [15:0] dac_code;
    logic [15:0] result;
    logic [1:0]  range_act;
    logic        result_bad;
    logic        idle_overrun;
    logic [15:0] vin = 16'h0000;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    // behavioural comparator: input at or above trial level
    assign cmp_in = (vin >= dac_code);

    sar_seq #(.IDLE_MAX(IDLE_LIM)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_start_n(conv_start_n),
        .cmp_in      (cmp_in),
        .mode_sel    (mode_sel),
        .range_sel   (range_sel),
        .twos_sel    (twos_sel),
        .busy        (busy),
        .dac_code    (dac_code),
        .result      (result),
        .range_act   (range_act),
        .result_bad  (result_bad),
        .idle_overrun(idle_overrun)
    );

    // {mode, range, twos, input code, expected result}
    localparam logic [36:0] VEC [0:7] = '{
        {2'b01, 2'b00, 1'b0, 16'h0000, 16'h0000},
        {2'b01, 2'b01, 1'b0, 16'hFFFF, 16'hFFFF},
        {2'b00, 2'b10, 1'b1, 16'h8000, 16'h0000},
        {2'b00, 2'b11, 1'b1, 16'h7FFF, 16'hFFFF},
        {2'b10, 2'b11, 1'b0, 16'h1234, 16'h1234},
        {2'b10, 2'b00, 1'b1, 16'hA5C3, 16'hA5C3},
        {2'b11, 2'b10, 1'b1, 16'h0001, 16'h8001},
        {2'b01, 2'b10, 1'b0, 16'hC001, 16'hC001}
    };

    function automatic int len_for(input logic [1:0] m);
        return (m == 2'b01) ? 64 : (m == 2'b10) ? 96 : 80;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_conv(input logic [1:0] m, input logic [1:0] r,
                           input logic t, input logic [15:0] v,
                           output int blen, output logic [15:0] first);
        @(negedge clk);
        mode_sel = m; range_sel = r; twos_sel = t; vin = v;
        conv_start_n = 1'b0;
        @(negedge clk);
        first = dac_code;
        blen = 0;
        while (busy && blen < 1000) begin
            blen++;
            @(negedge clk);
        end
        conv_start_n = 1'b1;
    endtask

    initial begin
        int          blen;
        logic [15:0] first;

        gap(3);
        // R11 reset values
        check("R11", "busy", busy, 0);
        check("R11", "result", result, 0);
        check("R11", "flags", {result_bad, idle_overrun}, 0);
        check("R11", "range_act/dac", {range_act, dac_code}, 0);
        rst_n = 1'b1;
        gap(8);

        // vector table: R2 search, R3 length, R7 coding
        for (int i = 0; i < 8; i++) begin
            do_conv(VEC[i][36:35], VEC[i][34:33], VEC[i][32], VEC[i][31:16], blen, first);
            check("R2", "first trial", first, 16'h8000);
            check("R7", "result", result, VEC[i][15:0]);
            check("R3", "busy length", blen, len_for(VEC[i][36:35]));
            check("R6", "range_act", range_act, VEC[i][34:33]);
            check("R9", "result_bad", result_bad, 0);
            gap(6);
        end

        // R5: start edge during busy is ignored, held low does not retrigger
        @(negedge clk);
        mode_sel = 2'b00; range_sel = 2'b00; twos_sel = 1'b0; vin = 16'h3C3C;
        conv_start_n = 1'b0;
        blen = 0;
        @(negedge clk);
        repeat (20) begin blen++; @(negedge clk); end
        conv_start_n = 1'b1;
        @(negedge clk); blen++;
        conv_start_n = 1'b0;
        while (busy && blen < 1000) begin blen++; @(negedge clk); end
        check("R5", "length with mid edge", blen, 80);
        check("R5", "result with mid edge", result, 16'h3C3C);
        gap(10);
        check("R5", "held low no restart", busy, 0);
        conv_start_n = 1'b1;
        gap(6);

        // R5: edge during acquisition is ignored
        do_conv(2'b00, 2'b00, 1'b0, 16'h0F0F, blen, first);
        @(negedge clk);
        conv_start_n = 1'b0;
        gap(10);
        check("R5", "edge in acquisition", busy, 0);
        conv_start_n = 1'b1;
        gap(6);

        // R6: settings changed mid-conversion apply next time
        @(negedge clk);
        mode_sel = 2'b01; range_sel = 2'b10; twos_sel = 1'b1; vin = 16'h0000;
        conv_start_n = 1'b0;
        @(negedge clk);
        mode_sel = 2'b10; range_sel = 2'b00; twos_sel = 1'b0;
        blen = 0;
        while (busy && blen < 1000) begin blen++; @(negedge clk); end
        conv_start_n = 1'b1;
        check("R6", "range_act held", range_act, 2'b10);
        check("R6", "old mode length", blen, 64);
        check("R6", "old coding", result, 16'h8000);
        gap(6);
        do_conv(2'b10, 2'b00, 1'b0, 16'h0000, blen, first);
        check("R6", "new mode length", blen, 96);
        check("R6", "new coding", result, 16'h0000);
        check("R6", "new range_act", range_act, 2'b00);
        gap(6);

        // R10: no idle limit after a normal conversion
        do_conv(2'b00, 2'b00, 1'b0, 16'h1111, blen, first);
        gap(300);
        check("R10", "no overrun in normal", idle_overrun, 0);
        do_conv(2'b10, 2'b00, 1'b0, 16'h2222, blen, first);
        check("R10", "result_bad after long normal idle", result_bad, 0);
        gap(300);
        check("R10", "no overrun in impulse", idle_overrun, 0);
        gap(6);

        // R8 / R9: fast-mode idle limit
        do_conv(2'b01, 2'b00, 1'b0, 16'h3333, blen, first);
        gap(60);
        check("R8", "short idle no flag", idle_overrun, 0);
        do_conv(2'b01, 2'b00, 1'b0, 16'h4444, blen, first);
        check("R9", "short idle result ok", result_bad, 0);
        gap(150);
        check("R8", "long idle flag", idle_overrun, 1);
        do_conv(2'b01, 2'b00, 1'b0, 16'h5555, blen, first);
        check("R9", "result after overrun", result_bad, 1);
        check("R9", "value still produced", result, 16'h5555);
        gap(6);
        do_conv(2'b01, 2'b00, 1'b0, 16'h6666, blen, first);
        check("R9", "following result ok", result_bad, 0);
        check("R8", "flag sticky", idle_overrun, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule